// File: doc/BRIEF.md
# Diagnosis and Interrupt-Enable Register Bank

This block sits behind a serial front end that has already framed and decoded a 16-bit access word. For each access strobe it decodes the two top address bits, the read-select bit and the read-only bit. It returns a response word one cycle later. It also captures line-fault and supply-monitor levels, and it routes three event sources either to a level interrupt output or to a one-cycle reset request.

Two registers live here. The diagnosis register is read at address 00. It carries a prioritised line-fault code, a live secondary-regulator health bit and a sticky main-supply undervoltage flag. Reading this register re-arms the flag. A diagnosis access with bit 12 low also passes the low twelve frame bits on to an external mode register. The enable register is at address 01. It holds three enable bits that decide how each source is handled: watchdog expiry, a crossing of the temperature warning, and a serial clock-count fault. Through the same address the pending-event flags can be read, and that read clears them.

Top module: `diag_irq_bank`

## Requirements
- R1: A diagnosis read (frame bits 15:14 = 00) returns, one cycle after the strobe, the frame's bits 15:12 echoed in bits 15:12, zeros in bits 11:7 and 1:0, a one in bit 3, the line code in bits 6:5, the secondary-supply health bit in bit 4 and the main-supply health bit in bit 2.
- R2: The line code is 11 when the transmit input is clamped dominant, else 10 when the bus is shorted to ground, else 01 when it is shorted to battery, else 00. Monitor levels are registered once before a read sees them.
- R3: Bit 4 of the diagnosis word is 0 while the secondary regulator reports overload, and 1 otherwise.
- R4: Bit 2 of the diagnosis word reads 0 if main-supply undervoltage was seen at any time since the previous diagnosis read. That read sets the bit back to 1, unless undervoltage is present in the same cycle as the read, in which case the bit stays 0.
- R5: A diagnosis access with frame bit 12 = 0 pulses modeWrStb for one cycle and presents the frame's bits 11:0 on modeWrData. With bit 12 = 1 there is no pulse.
- R6: At address 01 with bit 12 = 0, frame bits 11, 10 and 8 load the watchdog, temperature and clock-fault enables. With bit 13 = 0 the response holds the enables that were set before the access, in those same bit positions, and all other payload bits are 0.
- R7: A watchdog overflow while in standby mode (opMode 01), with the watchdog enable set, sets the watchdog pending flag. Any other watchdog overflow pulses resetReq in the next cycle.
- R8: With the temperature enable set, a change of the warning input in either direction sets the temperature pending flag. With the enable clear, it sets nothing.
- R9: A clock-count fault in start-up (10) or restart (11) mode pulses resetReq. In other modes it sets the clock-fault pending flag if that enable is set, and otherwise it has no effect.
- R10: A read at address 01 with bit 13 = 1 returns the pending flags in bits 11 (watchdog), 10 (temperature) and 8 (clock fault), then clears them. An event in the same cycle as that read leaves its flag set.
- R11: irqOut is high exactly while some pending flag has its enable set. Clearing an enable masks its flag without discarding it.
- R12: Accesses at addresses 10 and 11 produce no response, no mode pulse and no change to the enables.
- R13: After reset, irqOut, resetReq, respValid and modeWrStb are 0, all enables are 0, and bit 2 of the diagnosis word reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStb | input | 1 | One-cycle strobe for a decoded access |
| frameWord | input | 16 | Access word that comes with the strobe |
| clkCntErr | input | 1 | Pulse from the front end: wrong clock count |
| txdClamped | input | 1 | Transmit input stuck dominant |
| busGndShort | input | 1 | Bus shorted to ground |
| busBatShort | input | 1 | Bus shorted to battery |
| v3Overload | input | 1 | Secondary regulator shut off by overload |
| v1Under | input | 1 | Main supply below undervoltage threshold |
| tempWarn | input | 1 | Temperature warning level |
| wdOverflow | input | 1 | Pulse from the watchdog: overflow |
| opMode | input | 2 | 00 normal, 01 standby, 10 start-up, 11 restart |
| respValid | output | 1 | Response word valid |
| respWord | output | 16 | Response word |
| modeWrStb | output | 1 | Write pulse for the external mode register |
| modeWrData | output | 12 | Data for the mode register write |
| irqOut | output | 1 | Interrupt request level |
| resetReq | output | 1 | One-cycle reset request |

## Verification
The hardest cases to reach are the collisions: an event that arrives in the same cycle as the read that would clear its flag, both for the sticky supply bit and for the pending flags. Each is forced by raising the event input while the access strobe is driven in the same clock. The bench then reads twice. The first response must show the state from before the event, and the second must show that the event won. Masking is reached by clearing an enable while its flag is pending and then setting it again, so that the flag is shown to survive.

// File: rtl/diag_irq_pkg.sv
package diag_irq_pkg;
  localparam int FRAME_W   = 16;
  localparam int PAYLOAD_W = 12;
  localparam int HDR_W     = FRAME_W - PAYLOAD_W;
  localparam int NUM_SRC   = 3;
  localparam int LINE_W    = 2;

  // source indices
  localparam int SRC_SPIF = 0;
  localparam int SRC_OT   = 1;
  localparam int SRC_WT   = 2;

  // payload bit positions shared by enable, feedback and pending words
  localparam int SRC_POS [NUM_SRC] = '{8, 10, 11};

  // diagnosis word positions
  localparam int LINE_LSB = 5;
  localparam int V3_BIT   = 4;
  localparam int ONE_BIT  = 3;
  localparam int V1_BIT   = 2;

  typedef enum logic [1:0] {
    OP_NORMAL  = 2'b00,
    OP_STANDBY = 2'b01,
    OP_STARTUP = 2'b10,
    OP_RESTART = 2'b11
  } opMode_e;

  typedef struct packed {
    logic               rdDiag;
    logic               wrMode;
    logic               rdIrq;
    logic               rdEnFb;
    logic               wrEn;
    logic [NUM_SRC-1:0] setSrc;
    logic               rstPulse;
  } ctrlStrb_t;
endpackage

// File: rtl/diag_irq_ctrl.sv
module diag_irq_ctrl
  import diag_irq_pkg::*;
(
  input  logic               frameStb,
  input  logic [HDR_W-1:0]   frameHdr,
  input  logic [1:0]         opMode,
  input  logic               wdOverflow,
  input  logic               clkCntErr,
  input  logic               tempEdge,
  input  logic [NUM_SRC-1:0] enBits,
  output ctrlStrb_t          strb
);
  logic [1:0] addr;
  logic       rdSel, rdOnly, hitDiag, hitIrq, standby, booting, wdIrq, spifIrq;

  assign addr    = frameHdr[HDR_W-1 -: 2];
  assign rdSel   = frameHdr[1];
  assign rdOnly  = frameHdr[0];
  assign hitDiag = frameStb && (addr == 2'b00);
  assign hitIrq  = frameStb && (addr == 2'b01);
  assign standby = (opMode == OP_STANDBY);
  assign booting = (opMode == OP_STARTUP) || (opMode == OP_RESTART);
  assign wdIrq   = wdOverflow && standby && enBits[SRC_WT];
  assign spifIrq = clkCntErr && !booting && enBits[SRC_SPIF];

  always_comb begin
    strb                 = '0;
    strb.rdDiag          = hitDiag;
    strb.wrMode          = hitDiag && !rdOnly;
    strb.rdIrq           = hitIrq && rdSel;
    strb.rdEnFb          = hitIrq && !rdSel;
    strb.wrEn            = hitIrq && !rdOnly;
    strb.setSrc[SRC_WT]  = wdIrq;
    strb.setSrc[SRC_OT]  = tempEdge && enBits[SRC_OT];
    strb.setSrc[SRC_SPIF] = spifIrq;
    strb.rstPulse        = (wdOverflow && !wdIrq) || (clkCntErr && booting);
  end
endmodule

// File: rtl/diag_irq_dp.sv
module diag_irq_dp
  import diag_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [FRAME_W-1:0]   frameWord,
  input  logic                 txdClamped,
  input  logic                 busGndShort,
  input  logic                 busBatShort,
  input  logic                 v3Overload,
  input  logic                 v1Under,
  input  logic                 tempWarn,
  output logic [NUM_SRC-1:0]   enBits,
  output logic [NUM_SRC-1:0]   pend,
  output logic                 tempEdge,
  output logic                 respValid,
  output logic [FRAME_W-1:0]   respWord,
  output logic                 modeWrStb,
  output logic [PAYLOAD_W-1:0] modeWrData,
  output logic                 resetReq
);
  logic [LINE_W-1:0]    lineCode, lineNext;
  logic                 v3Ok, v1Fail, tempPrev;
  logic [PAYLOAD_W-1:0] enPayload, pendPayload, diagPayload, respPayload;

  always_comb begin
    if (txdClamped)       lineNext = 2'b11;
    else if (busGndShort) lineNext = 2'b10;
    else if (busBatShort) lineNext = 2'b01;
    else                  lineNext = 2'b00;
  end

  assign tempEdge = tempWarn ^ tempPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCode <= '0;
      v3Ok     <= 1'b1;
      v1Fail   <= 1'b0;
      tempPrev <= 1'b0;
    end else begin
      lineCode <= lineNext;
      v3Ok     <= !v3Overload;
      tempPrev <= tempWarn;
      if (v1Under)          v1Fail <= 1'b1;
      else if (strb.rdDiag) v1Fail <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enBits[i] <= 1'b0;
        pend[i]   <= 1'b0;
      end else begin
        if (strb.wrEn)           enBits[i] <= frameWord[SRC_POS[i]];
        if (strb.setSrc[i])      pend[i]   <= 1'b1;
        else if (strb.rdIrq)     pend[i]   <= 1'b0;
      end
    end
  end

  always_comb begin
    enPayload   = '0;
    pendPayload = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      enPayload[SRC_POS[i]]   = enBits[i];
      pendPayload[SRC_POS[i]] = pend[i];
    end
    diagPayload = '0;
    diagPayload[LINE_LSB +: LINE_W] = lineCode;
    diagPayload[V3_BIT]  = v3Ok;
    diagPayload[ONE_BIT] = 1'b1;
    diagPayload[V1_BIT]  = !v1Fail;
    if (strb.rdDiag)     respPayload = diagPayload;
    else if (strb.rdIrq) respPayload = pendPayload;
    else                 respPayload = enPayload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respWord   <= '0;
      modeWrStb  <= 1'b0;
      modeWrData <= '0;
      resetReq   <= 1'b0;
    end else begin
      respValid <= strb.rdDiag || strb.rdIrq || strb.rdEnFb;
      if (strb.rdDiag || strb.rdIrq || strb.rdEnFb)
        respWord <= {frameWord[FRAME_W-1 -: HDR_W], respPayload};
      modeWrStb <= strb.wrMode;
      if (strb.wrMode) modeWrData <= frameWord[PAYLOAD_W-1:0];
      resetReq <= strb.rstPulse;
    end
  end
endmodule

// File: rtl/diag_irq_bank.sv
module diag_irq_bank
  import diag_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameStb,
  input  logic [FRAME_W-1:0]   frameWord,
  input  logic                 clkCntErr,
  input  logic                 txdClamped,
  input  logic                 busGndShort,
  input  logic                 busBatShort,
  input  logic                 v3Overload,
  input  logic                 v1Under,
  input  logic                 tempWarn,
  input  logic                 wdOverflow,
  input  logic [1:0]           opMode,
  output logic                 respValid,
  output logic [FRAME_W-1:0]   respWord,
  output logic                 modeWrStb,
  output logic [PAYLOAD_W-1:0] modeWrData,
  output logic                 irqOut,
  output logic                 resetReq
);
  ctrlStrb_t          strb;
  logic [NUM_SRC-1:0] enBits, pend;
  logic               tempEdge;

  diag_irq_ctrl u_ctrl (
    .frameStb   (frameStb),
    .frameHdr   (frameWord[FRAME_W-1 -: HDR_W]),
    .opMode     (opMode),
    .wdOverflow (wdOverflow),
    .clkCntErr  (clkCntErr),
    .tempEdge   (tempEdge),
    .enBits     (enBits),
    .strb       (strb)
  );

  diag_irq_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .frameWord   (frameWord),
    .txdClamped  (txdClamped),
    .busGndShort (busGndShort),
    .busBatShort (busBatShort),
    .v3Overload  (v3Overload),
    .v1Under     (v1Under),
    .tempWarn    (tempWarn),
    .enBits      (enBits),
    .pend        (pend),
    .tempEdge    (tempEdge),
    .respValid   (respValid),
    .respWord    (respWord),
    .modeWrStb   (modeWrStb),
    .modeWrData  (modeWrData),
    .resetReq    (resetReq)
  );

  assign irqOut = |(pend & enBits);
endmodule

// File: rtl/diag_irq_chk.sv
module diag_irq_chk
  import diag_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 frameStb,
  input logic [FRAME_W-1:0]   frameWord,
  input logic                 clkCntErr,
  input logic                 wdOverflow,
  input logic [1:0]           opMode,
  input logic [NUM_SRC-1:0]   enBits,
  input logic                 respValid,
  input logic [FRAME_W-1:0]   respWord,
  input logic                 modeWrStb,
  input logic [PAYLOAD_W-1:0] modeWrData,
  input logic                 irqOut,
  input logic                 resetReq
);
  a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respWord[FRAME_W-1 -: 2] == 2'b00) |->
      (respWord[11:7] == 5'b0 && respWord[ONE_BIT] && respWord[1:0] == 2'b00));

  a_r5_mode_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && frameWord[15:14] == 2'b00 && !frameWord[12]) |=>
      (modeWrStb && modeWrData == $past(frameWord[PAYLOAD_W-1:0])));

  a_r7_wd_irq: assert property (@(posedge clk) disable iff (!rstN)
    (wdOverflow && !frameStb && opMode == OP_STANDBY && enBits[SRC_WT]) |=>
      (irqOut && !resetReq));

  a_r7_wd_reset: assert property (@(posedge clk) disable iff (!rstN)
    (wdOverflow && !(opMode == OP_STANDBY && enBits[SRC_WT])) |=> resetReq);

  a_r9_boot_reset: assert property (@(posedge clk) disable iff (!rstN)
    (clkCntErr && opMode[1]) |=> resetReq);

  a_r12_unmapped: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && frameWord[15]) |=> (!respValid && !modeWrStb));
endmodule

bind diag_irq_bank diag_irq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameStb   (frameStb),
  .frameWord  (frameWord),
  .clkCntErr  (clkCntErr),
  .wdOverflow (wdOverflow),
  .opMode     (opMode),
  .enBits     (enBits),
  .respValid  (respValid),
  .respWord   (respWord),
  .modeWrStb  (modeWrStb),
  .modeWrData (modeWrData),
  .irqOut     (irqOut),
  .resetReq   (resetReq)
);

// File: tb/diag_irq_bank_tb.sv
module diag_irq_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStb = 1'b0;
  logic [15:0] frameWord = '0;
  logic        clkCntErr = 1'b0, txdClamped = 1'b0, busGndShort = 1'b0, busBatShort = 1'b0;
  logic        v3Overload = 1'b0, v1Under = 1'b0, tempWarn = 1'b0, wdOverflow = 1'b0;
  logic [1:0]  opMode = 2'b00;
  logic        respValid, modeWrStb, irqOut, resetReq;
  logic [15:0] respWord;
  logic [11:0] modeWrData;

  int total = 0, failed = 0;
  bit done = 1'b0;
  logic        capValid, capModeStb;
  logic [15:0] capResp;
  logic [11:0] capModeData;

  always #2 clk = ~clk;

  diag_irq_bank u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // one access; called at a negedge, returns at the next one with the response captured
  task automatic access(input logic [15:0] w);
    frameStb = 1'b1;
    frameWord = w;
    @(negedge clk);
    capValid = respValid;
    capResp = respWord;
    capModeStb = modeWrStb;
    capModeData = modeWrData;
    frameStb = 1'b0;
    frameWord = '0;
  endtask

  task automatic t_reset();
    chk("R13 irqOut", irqOut, 0);
    chk("R13 resetReq", resetReq, 0);
    chk("R13 respValid", respValid, 0);
    chk("R13 modeWrStb", modeWrStb, 0);
    access(16'h5000);
    chk("R13 enables zero", capResp, 16'h5000);
    access(16'h3000);
    chk("R1 valid", capValid, 1);
    chk("R1 R13 idle diag word", capResp, 16'h301C);
  endtask

  task automatic t_line();
    txdClamped = 1; busGndShort = 1; tick();
    access(16'h3000); chk("R2 clamped wins", capResp, 16'h307C);
    txdClamped = 0; busBatShort = 1; tick();
    access(16'h3000); chk("R2 ground over battery", capResp, 16'h305C);
    busGndShort = 0; tick();
    access(16'h3000); chk("R2 battery", capResp, 16'h303C);
    busBatShort = 0; tick();
    access(16'h3000); chk("R2 none", capResp, 16'h301C);
  endtask

  task automatic t_v3();
    v3Overload = 1; tick();
    access(16'h3000); chk("R3 overload", capResp, 16'h300C);
    v3Overload = 0; tick();
    access(16'h3000); chk("R3 recovered", capResp, 16'h301C);
  endtask

  task automatic t_v1();
    v1Under = 1; tick(); v1Under = 0; tick();
    access(16'h3000); chk("R4 sticky low", capResp, 16'h3018);
    access(16'h3000); chk("R4 rearmed by read", capResp, 16'h301C);
    v1Under = 1;
    access(16'h3000);
    v1Under = 0;
    chk("R4 collision read shows old", capResp, 16'h301C);
    access(16'h3000); chk("R4 event wins over read", capResp, 16'h3018);
    access(16'h3000); chk("R4 rearmed after collision", capResp, 16'h301C);
  endtask

  task automatic t_mode();
    access(16'h2ABC);
    chk("R5 mode pulse", capModeStb, 1);
    chk("R5 mode data", capModeData, 12'hABC);
    chk("R1 header echo", capResp, 16'h201C);
    access(16'h3123);
    chk("R5 read-only no pulse", capModeStb, 0);
  endtask

  task automatic t_enable();
    access(16'h4D00); chk("R6 write returns old", capResp, 16'h4000);
    access(16'h5000); chk("R6 feedback", capResp, 16'h5D00);
    access(16'h5000 | 16'h0100); chk("R6 read-only keeps", capResp, 16'h5D00);
    access(16'h5000); chk("R6 unchanged after ro", capResp, 16'h5D00);
    access(16'h42FF); access(16'h5000); chk("R6 other bits ignored", capResp, 16'h5000);
  endtask

  task automatic t_watchdog();
    access(16'h4800);
    opMode = 2'b01; wdOverflow = 1; tick(); wdOverflow = 0;
    chk("R7 standby irq", irqOut, 1);
    chk("R7 no reset", resetReq, 0);
    access(16'h7000); chk("R10 watchdog pending", capResp, 16'h7800);
    chk("R10 cleared", irqOut, 0);
    opMode = 2'b00; wdOverflow = 1; tick(); wdOverflow = 0;
    chk("R7 normal reset", resetReq, 1);
    chk("R7 normal no irq", irqOut, 0);
    tick(); chk("R7 reset one cycle", resetReq, 0);
    access(16'h4000);
    opMode = 2'b01; wdOverflow = 1; tick(); wdOverflow = 0;
    chk("R7 disabled reset", resetReq, 1);
    opMode = 2'b00;
    access(16'h7000); chk("R7 no flag when reset", capResp, 16'h7000);
  endtask

  task automatic t_temp();
    access(16'h4400);
    tempWarn = 1; tick();
    chk("R8 rising irq", irqOut, 1);
    access(16'h7000); chk("R8 temp pending", capResp, 16'h7400);
    tempWarn = 0; tick();
    chk("R8 falling irq", irqOut, 1);
    access(16'h7000);
    access(16'h4000);
    tempWarn = 1; tick(); tempWarn = 0; tick();
    chk("R8 disabled no irq", irqOut, 0);
    access(16'h7000); chk("R8 disabled no flag", capResp, 16'h7000);
  endtask

  task automatic t_spif();
    access(16'h4100);
    clkCntErr = 1; tick(); clkCntErr = 0;
    chk("R9 normal irq", irqOut, 1);
    chk("R9 normal no reset", resetReq, 0);
    access(16'h7000); chk("R9 pending", capResp, 16'h7100);
    opMode = 2'b10; clkCntErr = 1; tick(); clkCntErr = 0;
    chk("R9 startup reset", resetReq, 1);
    chk("R9 startup no irq", irqOut, 0);
    opMode = 2'b11; clkCntErr = 1; tick(); clkCntErr = 0;
    chk("R9 restart reset", resetReq, 1);
    opMode = 2'b00;
    access(16'h4000);
    clkCntErr = 1; tick(); clkCntErr = 0;
    chk("R9 disabled no irq", irqOut, 0);
    chk("R9 disabled no reset", resetReq, 0);
    access(16'h7000); chk("R9 disabled no flag", capResp, 16'h7000);
  endtask

  task automatic t_collide_mask();
    access(16'h4100);
    clkCntErr = 1;
    access(16'h7000);
    clkCntErr = 0;
    chk("R10 collision old value", capResp, 16'h7000);
    chk("R10 event survives", irqOut, 1);
    access(16'h4000);
    chk("R11 masked", irqOut, 0);
    access(16'h4100);
    chk("R11 unmasked again", irqOut, 1);
    access(16'h7000); chk("R10 R11 retained flag", capResp, 16'h7100);
    chk("R10 cleared after read", irqOut, 0);
  endtask

  task automatic t_unmapped();
    access(16'h4D00);
    access(16'h8000);
    chk("R12 no resp 10", capValid, 0);
    access(16'hC000);
    chk("R12 no resp 11", capValid, 0);
    chk("R12 no mode pulse", capModeStb, 0);
    access(16'h5000); chk("R12 enables kept", capResp, 16'h5D00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    t_reset();
    t_line();
    t_v3();
    t_v1();
    t_mode();
    t_enable();
    t_watchdog();
    t_temp();
    t_spif();
    t_collide_mask();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule